// File: doc/BRIEF.md
# Whole-Space Bank Enable Decoder

This block turns the memory cycles of an 8-bit CPU into per-bank read and write chip enables. There is no fixed common window: the whole 64 KB address space is banked at once. A bank latch holds one read-enable and one write-enable bit per bank, five banks by default, and any combination of bits may be set. Bank 0 is ROM and banks 1 to 4 are RAM. Several banks can be readable and writable at the same moment. This lets software copy between banks (one bank readable, another writable, then a block move), broadcast one write to several banks, and write-protect any set of banks while still reading them.

The latch sits on one I/O port. Each I/O write to that port loads either the read mask or the write mask; bit 7 of the data picks which. A small two-state machine watches the I/O write strobe: LS_IDLE moves to LS_HELD on an I/O write to the port, and the latch loads on that transition. LS_HELD returns to LS_IDLE once the strobe drops. So each strobe loads the latch only once. The ROM takes reads inside its two windows, below 0x6000 and at or above 0xE000, and this resolves read conflicts there. Outside those windows, two or more readable RAM banks raise a contention flag.

Top module: `bank_enable_decoder`

## Requirements
- R1: After reset the read mask enables only bank 0 and the write mask enables only bank 1.
- R2: An I/O write (io_req and wr_strobe) to port 0x80 (cpu_addr[7:0]) loads cpu_data[4:0] into the read mask when cpu_data[7] is 0, or into the write mask when cpu_data[7] is 1. Bit n of a mask stands for bank n. I/O writes to any other port leave both masks unchanged.
- R3: An I/O write strobe held over several clocks loads the latch once only, with the data present on its first clock. Data changes while the strobe is held are ignored.
- R4: rd_sel bits are asserted only while mem_req and rd_strobe are both high. Outside the ROM windows, each read-enabled RAM bank (1 to 4) gets its rd_sel bit at any address.
- R5: rd_sel[0] is asserted for a read only if bank 0 is read-enabled and the address is below 0x6000 or at or above 0xE000. When it is asserted, every RAM bank's rd_sel is held low.
- R6: contention is high during a read exactly when two or more RAM bank rd_sel bits are asserted, and low otherwise.
- R7: During mem_req with wr_strobe, wr_sel is asserted for every write-enabled bank from 1 to 4 at the same time (broadcast), at any address.
- R8: wr_sel[0] is never asserted, even if bank 0's write-enable bit is set.
- R9: A bank whose write-enable bit is clear gets no wr_sel, but it still gets rd_sel when it is read-enabled.
- R10: The read and write masks are independent. A read cycle selects only the source banks and a write cycle selects only the destination banks.
- R11: A new latch value is in effect for the first memory cycle after the clock edge that loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address bus; the low byte is the I/O port number |
| cpu_data | input | 8 | CPU data bus, used for latch writes |
| mem_req | input | 1 | Memory cycle in progress |
| io_req | input | 1 | I/O cycle in progress |
| rd_strobe | input | 1 | Read strobe |
| wr_strobe | input | 1 | Write strobe |
| rd_sel | output | 5 | Per-bank read select |
| wr_sel | output | 5 | Per-bank write select |
| contention | output | 1 | Two or more RAM banks would drive a read |

## Verification
Reads are tried with a single bank enabled, with ROM plus RAM enabled, and with several RAM banks enabled. The test addresses sit just either side of 0x6000 and 0xE000, which separates ROM priority inside the windows from RAM access outside them and from true contention. Writes are tried with all bits set, with a sparse mask and with disjoint read and write masks. This separates broadcast writes, the ROM write block and write-protect with reads still allowed. A strobe held while its data changes, and a write to a foreign port, show that the latch loads once per strobe and only at its own port.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;
    typedef enum logic {
        LS_IDLE,
        LS_HELD
    } latch_state_e;
endpackage

// File: rtl/bank_latch_fsm.sv
module bank_latch_fsm
    import bank_dec_pkg::*;
#(
    parameter int NUM_BANKS = 5,
    parameter int DATA_W    = 8,
    parameter int PORT_W    = 8,
    parameter logic [PORT_W-1:0] LATCH_PORT = 8'h80
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PORT_W-1:0]    port,
    input  logic [DATA_W-1:0]    data,
    input  logic                 io_req,
    input  logic                 wr_strobe,
    output logic [NUM_BANKS-1:0] rd_mask,
    output logic [NUM_BANKS-1:0] wr_mask
);
    localparam logic [NUM_BANKS-1:0] RST_RD = NUM_BANKS'(1);
    localparam logic [NUM_BANKS-1:0] RST_WR = NUM_BANKS'(2);
    localparam int SEL_BIT = DATA_W - 1;

    latch_state_e state_q, state_d;
    logic io_wr, hit, load;

    assign io_wr = io_req && wr_strobe;
    assign hit   = io_wr && (port == LATCH_PORT);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            LS_IDLE: if (hit) begin
                state_d = LS_HELD;
                load    = 1'b1;
            end
            LS_HELD: if (!io_wr) state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mask <= RST_RD;
            wr_mask <= RST_WR;
        end else if (load) begin
            if (data[SEL_BIT]) wr_mask <= data[NUM_BANKS-1:0];
            else               rd_mask <= data[NUM_BANKS-1:0];
        end
    end
endmodule

// File: rtl/bank_read_resolver.sv
module bank_read_resolver #(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] ROM_LO_END  = 16'h6000,
    parameter logic [ADDR_W-1:0] ROM_HI_BASE = 16'hE000
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 rd_cycle,
    input  logic [NUM_BANKS-1:0] rd_mask,
    output logic [NUM_BANKS-1:0] rd_sel,
    output logic                 contention
);
    localparam int CNT_W = $clog2(NUM_BANKS + 1);

    logic in_window, rom_take;
    logic [CNT_W-1:0] ram_cnt;

    assign in_window = (addr < ROM_LO_END) || (addr >= ROM_HI_BASE);
    assign rom_take  = rd_cycle && rd_mask[0] && in_window;
    assign rd_sel[0] = rom_take;

    for (genvar b = 1; b < NUM_BANKS; b++) begin : g_ram
        assign rd_sel[b] = rd_cycle && rd_mask[b] && !rom_take;
    end

    always_comb begin
        ram_cnt = '0;
        for (int b = 1; b < NUM_BANKS; b++)
            ram_cnt = ram_cnt + CNT_W'(rd_sel[b]);
    end

    assign contention = (ram_cnt >= CNT_W'(2));
endmodule

// File: rtl/bank_write_gate.sv
module bank_write_gate #(
    parameter int NUM_BANKS = 5
) (
    input  logic                 wr_cycle,
    input  logic [NUM_BANKS-1:0] wr_mask,
    output logic [NUM_BANKS-1:0] wr_sel
);
    assign wr_sel[0] = 1'b0;
    for (genvar b = 1; b < NUM_BANKS; b++) begin : g_ram
        assign wr_sel[b] = wr_cycle && wr_mask[b];
    end
endmodule

// File: rtl/bank_enable_decoder.sv
module bank_enable_decoder #(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int PORT_W    = 8,
    parameter logic [PORT_W-1:0] LATCH_PORT  = 8'h80,
    parameter logic [ADDR_W-1:0] ROM_LO_END  = 16'h6000,
    parameter logic [ADDR_W-1:0] ROM_HI_BASE = 16'hE000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_data,
    input  logic                 mem_req,
    input  logic                 io_req,
    input  logic                 rd_strobe,
    input  logic                 wr_strobe,
    output logic [NUM_BANKS-1:0] rd_sel,
    output logic [NUM_BANKS-1:0] wr_sel,
    output logic                 contention
);
    logic [NUM_BANKS-1:0] rd_mask, wr_mask;
    logic rd_cycle, wr_cycle;

    assign rd_cycle = mem_req && rd_strobe;
    assign wr_cycle = mem_req && wr_strobe;

    bank_latch_fsm #(
        .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .PORT_W(PORT_W), .LATCH_PORT(LATCH_PORT)
    ) u_latch (
        .clk(clk), .rst_n(rst_n), .port(cpu_addr[PORT_W-1:0]), .data(cpu_data),
        .io_req(io_req), .wr_strobe(wr_strobe), .rd_mask(rd_mask), .wr_mask(wr_mask)
    );

    bank_read_resolver #(
        .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W),
        .ROM_LO_END(ROM_LO_END), .ROM_HI_BASE(ROM_HI_BASE)
    ) u_read (
        .addr(cpu_addr), .rd_cycle(rd_cycle), .rd_mask(rd_mask),
        .rd_sel(rd_sel), .contention(contention)
    );

    bank_write_gate #(.NUM_BANKS(NUM_BANKS)) u_write (
        .wr_cycle(wr_cycle), .wr_mask(wr_mask), .wr_sel(wr_sel)
    );
endmodule

// File: rtl/bank_enable_decoder_checker.sv
module bank_enable_decoder_checker #(
    parameter int NUM_BANKS = 5,
    parameter int ADDR_W    = 16,
    parameter int PORT_W    = 8,
    parameter logic [PORT_W-1:0] LATCH_PORT  = 8'h80,
    parameter logic [ADDR_W-1:0] ROM_LO_END  = 16'h6000,
    parameter logic [ADDR_W-1:0] ROM_HI_BASE = 16'hE000
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic                 mem_req,
    input logic                 io_req,
    input logic                 rd_strobe,
    input logic                 wr_strobe,
    input logic [NUM_BANKS-1:0] rd_sel,
    input logic [NUM_BANKS-1:0] wr_sel,
    input logic                 contention,
    input logic [NUM_BANKS-1:0] rd_mask,
    input logic [NUM_BANKS-1:0] wr_mask
);
    logic port_wr;
    assign port_wr = io_req && wr_strobe && (cpu_addr[PORT_W-1:0] == LATCH_PORT);

    a_r4_read_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_sel) |-> (mem_req && rd_strobe));

    a_r7_write_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_sel) |-> (mem_req && wr_strobe));

    a_r8_rom_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wr_strobe) |-> !wr_sel[0]);

    a_r5_rom_excludes_ram: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[0] |-> (rd_sel[NUM_BANKS-1:1] == '0));

    a_r5_rom_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel[0] |-> ((cpu_addr < ROM_LO_END) || (cpu_addr >= ROM_HI_BASE)));

    a_r6_contention_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        contention |-> (mem_req && rd_strobe && !rd_sel[0]));

    a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && $past(port_wr)) |=> ($stable(rd_mask) && $stable(wr_mask)));
endmodule

bind bank_enable_decoder bank_enable_decoder_checker #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .PORT_W(PORT_W), .LATCH_PORT(LATCH_PORT),
    .ROM_LO_END(ROM_LO_END), .ROM_HI_BASE(ROM_HI_BASE)
) u_checker (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req), .io_req(io_req),
    .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .contention(contention), .rd_mask(rd_mask), .wr_mask(wr_mask)
);

// File: tb/bank_enable_decoder_tb.sv
module bank_enable_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mem_req = 1'b0, io_req = 1'b0, rd_strobe = 1'b0, wr_strobe = 1'b0;
    logic [4:0]  rd_sel, wr_sel;
    logic        contention;
    int          n_checks = 0;
    int          n_errors = 0;

    always #4 clk = ~clk;

    bank_enable_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mem_req(mem_req), .io_req(io_req), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .rd_sel(rd_sel), .wr_sel(wr_sel), .contention(contention)
    );

    task automatic chk(input string req, input logic [5:0] got, input logic [5:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic bus_idle();
        mem_req = 0; io_req = 0; rd_strobe = 0; wr_strobe = 0;
    endtask

    // I/O write held for one clock; latch loads on that edge
    task automatic io_write(input logic [7:0] port, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = {8'h00, port}; cpu_data = d; io_req = 1; wr_strobe = 1;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic mem_read(input logic [15:0] a, output logic [4:0] rs, output logic c);
        @(negedge clk);
        cpu_addr = a; mem_req = 1; rd_strobe = 1;
        #2; rs = rd_sel; c = contention;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic mem_write(input logic [15:0] a, output logic [4:0] ws, output logic [4:0] rs);
        @(negedge clk);
        cpu_addr = a; mem_req = 1; wr_strobe = 1;
        #2; ws = wr_sel; rs = rd_sel;
        @(negedge clk);
        bus_idle();
    endtask

    task automatic t_reset();
        logic [4:0] rs, ws; logic c;
        @(negedge clk);
        chk("R4 idle rd_sel", {1'b0, rd_sel}, 6'b0);
        mem_read(16'h0100, rs, c);
        chk("R1 reset read", {c, rs}, 6'b000001);
        mem_read(16'h8000, rs, c);
        chk("R5 rom outside window", {c, rs}, 6'b000000);
        mem_write(16'h8000, ws, rs);
        chk("R1 reset write", {1'b0, ws}, 6'b000010);
    endtask

    task automatic t_latch_load();
        logic [4:0] rs; logic c;
        io_write(8'h80, 8'h1E);
        mem_read(16'h8000, rs, c);   // R11: first cycle after load
        chk("R2 R11 read mask load", {c, rs}, 6'b111110);
        io_write(8'h81, 8'h04);
        mem_read(16'h8000, rs, c);
        chk("R2 foreign port ignored", {c, rs}, 6'b111110);
    endtask

    task automatic t_rom_priority();
        logic [4:0] rs; logic c;
        io_write(8'h80, 8'h03);
        mem_read(16'h5FFF, rs, c); chk("R5 below 0x6000", {c, rs}, 6'b000001);
        mem_read(16'h6000, rs, c); chk("R5 at 0x6000", {c, rs}, 6'b000010);
        mem_read(16'hDFFF, rs, c); chk("R5 below 0xE000", {c, rs}, 6'b000010);
        mem_read(16'hE000, rs, c); chk("R5 at 0xE000", {c, rs}, 6'b000001);
    endtask

    task automatic t_contention();
        logic [4:0] rs; logic c;
        io_write(8'h80, 8'h06);
        mem_read(16'h8000, rs, c); chk("R6 two ram banks", {c, rs}, 6'b100110);
        io_write(8'h80, 8'h07);
        mem_read(16'h0000, rs, c); chk("R6 rom resolves", {c, rs}, 6'b000001);
        mem_read(16'hA000, rs, c); chk("R4 R6 ram outside window", {c, rs}, 6'b100110);
    endtask

    task automatic t_broadcast();
        logic [4:0] ws, rs;
        io_write(8'h80, 8'h00);
        io_write(8'h80, 8'h9F);
        mem_write(16'h0000, ws, rs);
        chk("R7 R8 broadcast no rom", {1'b0, ws}, 6'b011110);
    endtask

    task automatic t_protect();
        logic [4:0] ws, rs; logic c;
        io_write(8'h80, 8'h94);
        io_write(8'h80, 8'h0A);
        mem_write(16'h9000, ws, rs);
        chk("R9 protected banks", {1'b0, ws}, 6'b010100);
        mem_read(16'h9000, rs, c);
        chk("R9 reads continue", {c, rs}, 6'b101010);
    endtask

    task automatic t_copy();
        logic [4:0] ws, rs; logic c;
        io_write(8'h80, 8'h02);
        io_write(8'h80, 8'h84);
        mem_read(16'h7000, rs, c);
        chk("R10 copy read", {c, rs}, 6'b000010);
        mem_write(16'h7000, ws, rs);
        chk("R10 copy write", {1'b0, ws}, 6'b000100);
        chk("R10 no read on write", {1'b0, rs}, 6'b000000);
    endtask

    task automatic t_held_strobe();
        logic [4:0] rs; logic c;
        @(negedge clk);
        cpu_addr = 16'h0080; cpu_data = 8'h10; io_req = 1; wr_strobe = 1;
        @(negedge clk); cpu_data = 8'h08;
        @(negedge clk); cpu_data = 8'h04;
        @(negedge clk); bus_idle();
        mem_read(16'h8000, rs, c);
        chk("R3 held strobe loads once", {c, rs}, 6'b010000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_latch_load();
                t_rom_priority();
                t_contention();
                t_broadcast();
                t_protect();
                t_copy();
                t_held_strobe();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule